// File: doc/BRIEF.md
# Boundary-Scan Test Access Port

This block is a serial test port run entirely from its own test clock, which need not relate to any system clock. A sixteen-state controller, steered only by the mode-select input, decides whether the port is idle, capturing, shifting or updating. While shifting, exactly one serial register sits between the serial input and the serial output. It is either a 3-bit instruction register, a 1-bit bypass stage, or a 320-cell boundary chain.

Each boundary cell has a parallel capture input and a registered parallel drive output. A test environment can therefore present pin values, scan them out, scan new values in and see them appear on the drive outputs. The serial input feeds the least-significant end of the selected register, and the most-significant end is presented on the serial output. The serial output changes only on falling test-clock edges, and a separate enable shows when it carries data.

Top module: `scan_tap_top`

## Requirements
- R1: While `test_rst` is high at a rising edge, the controller enters Test-Logic-Reset. At the next falling edge the active instruction becomes BYPASS (3'b111), `bnd_drive` becomes all zeros and `ser_out_en` becomes 0.
- R2: Five consecutive rising edges with `mode_sel` high bring the controller to Test-Logic-Reset from any state. The falling edge that follows restores the BYPASS instruction.
- R3: `mode_sel` and `ser_in` are sampled on rising edges. `ser_out` and `ser_out_en` change only on falling edges. `ser_out_en` is 1 exactly while the controller is in Shift-DR or Shift-IR.
- R4: Each shift moves `ser_in` into bit 0 of the selected register, and that register's highest bit is what `ser_out` presents. Captured data therefore leaves highest bit first.
- R5: Capture-IR loads 3'b001 into the instruction shifter. The first bit shifted in ends up in bit 2. The shifted code becomes active only at the falling edge in Update-IR, and the active code is unchanged while the shift is in progress.
- R6: Codes 3'b000 (EXTEST) and 3'b010 (SAMPLE/PRELOAD) select the boundary chain. Code 3'b111 and every other code select the bypass stage.
- R7: The bypass stage captures 0 in Capture-DR. A bypass scan therefore returns 0 first, followed by the input stream delayed by one bit.
- R8: Under a boundary instruction, Capture-DR loads `bnd_capture` into all 320 cells. Cell 319 is scanned out first.
- R9: `bnd_drive` changes only at the falling edge in Update-DR, and only under a boundary instruction. It then takes the cell contents, so the last bit shifted in lands in cell 0. It stays unchanged during shifting and under bypass.
- R10: `extest_on` is 1 exactly while the active instruction is EXTEST.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| test_clk | input | 1 | Dedicated test clock |
| test_rst | input | 1 | Synchronous active-high reset |
| mode_sel | input | 1 | Controller steering input |
| ser_in | input | 1 | Serial data input |
| ser_out | output | 1 | Serial data output, updated on falling edges |
| ser_out_en | output | 1 | High while `ser_out` carries shift data |
| bnd_capture | input | 320 | Parallel values captured into the boundary cells |
| bnd_drive | output | 320 | Parallel outputs of the boundary update stage |
| extest_on | output | 1 | Active instruction is EXTEST |

## Verification
A controller that is in the wrong state shows up within one falling edge: `ser_out_en` rises or drops at the wrong step of a scan, or a captured value comes out shifted by one position. A wrong active instruction shows as the wrong scan length: a bypass scan returns its input one bit late, while a boundary scan returns the captured pins. It also shows on `extest_on`, and on `bnd_drive` moving when it should not. A fault in cell ordering or shift direction shows on the first 320-bit scan as a reversed or rotated pattern, on both the serial output and `bnd_drive`.

// File: rtl/scan_tap_pkg.sv
package scan_tap_pkg;

  localparam int IR_W = 3;

  typedef enum logic [3:0] {
    ST_RESET, ST_IDLE,
    ST_DR_SEL, ST_DR_CAP, ST_DR_SHIFT, ST_DR_EXIT1, ST_DR_PAUSE, ST_DR_EXIT2, ST_DR_UPD,
    ST_IR_SEL, ST_IR_CAP, ST_IR_SHIFT, ST_IR_EXIT1, ST_IR_PAUSE, ST_IR_EXIT2, ST_IR_UPD
  } tap_state_e;

  localparam logic [IR_W-1:0] OP_EXTEST  = 3'b000;
  localparam logic [IR_W-1:0] OP_SAMPLE  = 3'b010;
  localparam logic [IR_W-1:0] OP_BYPASS  = 3'b111;
  localparam logic [IR_W-1:0] IR_CAP_PAT = 3'b001;

  function automatic tap_state_e tap_next(input tap_state_e s, input logic m);
    case (s)
      ST_RESET:    return m ? ST_RESET    : ST_IDLE;
      ST_IDLE:     return m ? ST_DR_SEL   : ST_IDLE;
      ST_DR_SEL:   return m ? ST_IR_SEL   : ST_DR_CAP;
      ST_DR_CAP:   return m ? ST_DR_EXIT1 : ST_DR_SHIFT;
      ST_DR_SHIFT: return m ? ST_DR_EXIT1 : ST_DR_SHIFT;
      ST_DR_EXIT1: return m ? ST_DR_UPD   : ST_DR_PAUSE;
      ST_DR_PAUSE: return m ? ST_DR_EXIT2 : ST_DR_PAUSE;
      ST_DR_EXIT2: return m ? ST_DR_UPD   : ST_DR_SHIFT;
      ST_DR_UPD:   return m ? ST_DR_SEL   : ST_IDLE;
      ST_IR_SEL:   return m ? ST_RESET    : ST_IR_CAP;
      ST_IR_CAP:   return m ? ST_IR_EXIT1 : ST_IR_SHIFT;
      ST_IR_SHIFT: return m ? ST_IR_EXIT1 : ST_IR_SHIFT;
      ST_IR_EXIT1: return m ? ST_IR_UPD   : ST_IR_PAUSE;
      ST_IR_PAUSE: return m ? ST_IR_EXIT2 : ST_IR_PAUSE;
      ST_IR_EXIT2: return m ? ST_IR_UPD   : ST_IR_SHIFT;
      default:     return m ? ST_DR_SEL   : ST_IDLE;
    endcase
  endfunction

  function automatic logic op_is_boundary(input logic [IR_W-1:0] op);
    return (op == OP_EXTEST) || (op == OP_SAMPLE);
  endfunction

endpackage

// File: rtl/tap_ctrl_fsm.sv
module tap_ctrl_fsm
  import scan_tap_pkg::*;
#(
  parameter int RESET_ONES = 5
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tms,
  output tap_state_e state
);

  localparam int CW = $clog2(RESET_ONES + 1);

  always_ff @(posedge clk) begin
    if (rst) state <= ST_RESET;
    else     state <= tap_next(state, tms);
  end

  // checker: run of consecutive high mode-select samples
  logic [CW-1:0] ones_cnt;
  always_ff @(posedge clk) begin
    if (rst || !tms)                            ones_cnt <= '0;
    else if (ones_cnt != CW'(RESET_ONES))       ones_cnt <= ones_cnt + 1'b1;
  end

  a_r2_ones_reach_reset: assert property (@(posedge clk) disable iff (rst)
    (ones_cnt == CW'(RESET_ONES)) |-> (state == ST_RESET));

endmodule

// File: rtl/tap_instr_reg.sv
module tap_instr_reg
  import scan_tap_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  tap_state_e      state,
  input  logic            tdi,
  output logic [IR_W-1:0] op_active,
  output logic            shift_msb
);

  logic [IR_W-1:0] ir_sh;

  always_ff @(posedge clk) begin
    if (rst)                        ir_sh <= IR_CAP_PAT;
    else if (state == ST_IR_CAP)    ir_sh <= IR_CAP_PAT;
    else if (state == ST_IR_SHIFT)  ir_sh <= {ir_sh[IR_W-2:0], tdi};
  end

  always_ff @(negedge clk) begin
    if (rst || state == ST_RESET)   op_active <= OP_BYPASS;
    else if (state == ST_IR_UPD)    op_active <= ir_sh;
  end

  assign shift_msb = ir_sh[IR_W-1];

  a_r5_active_holds: assert property (@(posedge clk) disable iff (rst)
    !(state inside {ST_IR_UPD, ST_RESET}) |-> $stable(op_active));

  a_r4_ir_lsb_entry: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IR_SHIFT) |=> (ir_sh[0] == $past(tdi)));

endmodule

// File: rtl/bsr_chain.sv
module bsr_chain
  import scan_tap_pkg::*;
#(
  parameter int LEN = 320
) (
  input  logic           clk,
  input  logic           rst,
  input  tap_state_e     state,
  input  logic           sel,
  input  logic           tdi,
  input  logic [LEN-1:0] cap_in,
  output logic [LEN-1:0] drive_out,
  output logic           msb
);

  logic [LEN-1:0] sh;
  logic cap_en, shift_en, upd_en;

  assign cap_en   = sel && (state == ST_DR_CAP);
  assign shift_en = sel && (state == ST_DR_SHIFT);
  assign upd_en   = sel && (state == ST_DR_UPD);

  for (genvar i = 0; i < LEN; i++) begin : g_cell
    logic from_prev;
    if (i == 0) begin : g_head
      assign from_prev = tdi;
    end else begin : g_body
      assign from_prev = sh[i-1];
    end

    always_ff @(posedge clk) begin
      if (rst)           sh[i] <= 1'b0;
      else if (cap_en)   sh[i] <= cap_in[i];
      else if (shift_en) sh[i] <= from_prev;
    end

    always_ff @(negedge clk) begin
      if (rst)         drive_out[i] <= 1'b0;
      else if (upd_en) drive_out[i] <= sh[i];
    end
  end

  assign msb = sh[LEN-1];

  a_r9_drive_only_in_update: assert property (@(posedge clk) disable iff (rst)
    !(sel && state == ST_DR_UPD) |-> $stable(drive_out));

  a_r8_capture_loads_pins: assert property (@(posedge clk) disable iff (rst)
    cap_en |=> (sh == $past(cap_in)));

endmodule

// File: rtl/scan_tap_top.sv
module scan_tap_top
  import scan_tap_pkg::*;
#(
  parameter int BSR_LEN = 320
) (
  input  logic               test_clk,
  input  logic               test_rst,
  input  logic               mode_sel,
  input  logic               ser_in,
  output logic               ser_out,
  output logic               ser_out_en,
  input  logic [BSR_LEN-1:0] bnd_capture,
  output logic [BSR_LEN-1:0] bnd_drive,
  output logic               extest_on
);

  tap_state_e      state;
  logic [IR_W-1:0] op_active;
  logic            ir_msb, bsr_msb, byp_q, bnd_sel, shifting;

  tap_ctrl_fsm #(.RESET_ONES(5)) u_fsm (
    .clk(test_clk), .rst(test_rst), .tms(mode_sel), .state(state)
  );

  tap_instr_reg u_ir (
    .clk(test_clk), .rst(test_rst), .state(state), .tdi(ser_in),
    .op_active(op_active), .shift_msb(ir_msb)
  );

  assign bnd_sel = op_is_boundary(op_active);

  bsr_chain #(.LEN(BSR_LEN)) u_bsr (
    .clk(test_clk), .rst(test_rst), .state(state), .sel(bnd_sel),
    .tdi(ser_in), .cap_in(bnd_capture), .drive_out(bnd_drive), .msb(bsr_msb)
  );

  always_ff @(posedge test_clk) begin
    if (test_rst)                                byp_q <= 1'b0;
    else if (!bnd_sel && state == ST_DR_CAP)     byp_q <= 1'b0;
    else if (!bnd_sel && state == ST_DR_SHIFT)   byp_q <= ser_in;
  end

  assign shifting = (state == ST_DR_SHIFT) || (state == ST_IR_SHIFT);

  always_ff @(negedge test_clk) begin
    if (test_rst) begin
      ser_out    <= 1'b0;
      ser_out_en <= 1'b0;
    end else begin
      ser_out_en <= shifting;
      if (state == ST_IR_SHIFT) ser_out <= ir_msb;
      else if (bnd_sel)         ser_out <= bsr_msb;
      else                      ser_out <= byp_q;
    end
  end

  assign extest_on = (op_active == OP_EXTEST);

  a_r3_enable_only_in_shift: assert property (@(posedge test_clk) disable iff (test_rst)
    ser_out_en |-> shifting);

  a_r3_enable_during_shift: assert property (@(posedge test_clk) disable iff (test_rst)
    (shifting && $past(shifting)) |-> ser_out_en);

endmodule

// File: tb/sim_scan_tap_top.sv
module sim_scan_tap_top;
  localparam int BL = 320;

  logic test_clk = 1'b0, test_rst = 1'b1, mode_sel = 1'b1, ser_in = 1'b0;
  logic ser_out, ser_out_en, extest_on;
  logic [BL-1:0] bnd_capture = '0, bnd_drive;

  int n_chk = 0, n_err = 0, oe_bad = 0, glitch = 0;
  logic [BL-1:0] mid_drive;
  logic mid_extest;

  always #5 test_clk = ~test_clk;

  scan_tap_top #(.BSR_LEN(BL)) u0 (.*);

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_err++;
    $display("FAIL watchdog: act=running exp=done");
    finish_run();
  end

  task automatic chk(input string req, input logic [BL-1:0] act, input logic [BL-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic m, input logic d, input logic oe_exp, output logic so);
    @(negedge test_clk); #1;
    so = ser_out;
    if (ser_out_en !== oe_exp) oe_bad++;
    mode_sel = m; ser_in = d;
    @(posedge test_clk); #1;
    if (ser_out !== so) glitch++;
  endtask

  task automatic scan_ir(input logic [2:0] code, output logic [2:0] cap);
    logic s;
    step(1, 0, 0, s); step(1, 0, 0, s); step(0, 0, 0, s); step(0, 0, 0, s);
    for (int k = 2; k >= 0; k--) begin
      step(k == 0, code[k], 1, s);
      cap[k] = s;
    end
    mid_extest = extest_on;
    step(1, 0, 0, s);
    step(0, 0, 0, s);
  endtask

  task automatic scan_dr(input int n, input logic [BL-1:0] vin, output logic [BL-1:0] vout);
    logic s;
    vout = '0;
    step(1, 0, 0, s); step(0, 0, 0, s); step(0, 0, 0, s);
    for (int k = n - 1; k >= 0; k--) begin
      step(k == 0, vin[k], 1, s);
      vout[k] = s;
    end
    step(1, 0, 0, s);
    mid_drive = bnd_drive;
    step(0, 0, 0, s);
  endtask

  function automatic logic [BL-1:0] rnd_vec(input int n);
    logic [BL-1:0] v = '0;
    for (int i = 0; i < n; i++) v[i] = 1'($urandom);
    return v;
  endfunction

  function automatic logic is_bnd(input logic [2:0] c);
    return (c == 3'b000) || (c == 3'b010);
  endfunction

  function automatic logic [BL-1:0] exp_out(input logic b, input int n,
      input logic [BL-1:0] vin, input logic [BL-1:0] pins);
    logic [BL-1:0] r = '0;
    if (!b) return vin >> 1;
    for (int k = 0; k < n; k++) r[n-1-k] = pins[BL-1-k];
    return r;
  endfunction

  function automatic logic [BL-1:0] exp_drive(input logic b, input int n,
      input logic [BL-1:0] vin, input logic [BL-1:0] pins, input logic [BL-1:0] old);
    if (!b) return old;
    return (pins << n) | vin;
  endfunction

  initial begin
    logic [2:0] cap;
    logic [BL-1:0] v, o, d_old;
    logic s;
    void'($urandom(32'd1149));
    repeat (3) @(posedge test_clk);
    @(negedge test_clk); #1;
    test_rst = 1'b0;
    // R1: reset state
    chk("R1 enable", BL'(ser_out_en), '0);
    chk("R1 drive", bnd_drive, '0);
    chk("R1 extest", BL'(extest_on), '0);
    step(0, 0, 0, s);
    // R7/R4: bypass default after reset, 0 first then delayed input
    v = rnd_vec(9); scan_dr(9, v, o);
    chk("R7 bypass stream", o, v >> 1);
    // R5: capture pattern 001 and SAMPLE load
    scan_ir(3'b010, cap);
    chk("R5 ir capture", BL'(cap), BL'(3'b001));
    chk("R10 sample not extest", BL'(extest_on), '0);
    // R8/R9: boundary scan
    bnd_capture = rnd_vec(BL); v = rnd_vec(BL);
    scan_dr(BL, v, o);
    chk("R8 capture out", o, bnd_capture);
    chk("R9 held during shift", mid_drive, '0);
    chk("R9 updated", bnd_drive, v);
    // R10/R5: EXTEST takes effect at Update-IR only
    scan_ir(3'b000, cap);
    chk("R5 active held in shift", BL'(mid_extest), '0);
    chk("R10 extest on", BL'(extest_on), BL'(1));
    for (int it = 0; it < 4; it++) begin
      bnd_capture = rnd_vec(BL); v = rnd_vec(BL);
      scan_dr(BL, v, o);
      chk("R8 extest capture", o, bnd_capture);
      chk("R9 extest update", bnd_drive, v);
    end
    // R6: undefined code behaves as bypass
    d_old = bnd_drive;
    scan_ir(3'b101, cap);
    chk("R6 undefined not extest", BL'(extest_on), '0);
    v = rnd_vec(7); scan_dr(7, v, o);
    chk("R6 undefined bypass", o, v >> 1);
    chk("R9 bypass keeps drive", bnd_drive, d_old);
    // R6: random codes checked against model
    for (int it = 0; it < 10; it++) begin
      logic [2:0] c = 3'($urandom);
      int n = 2 + int'($urandom % 12);
      d_old = bnd_drive;
      bnd_capture = rnd_vec(BL);
      scan_ir(c, cap);
      v = rnd_vec(n); scan_dr(n, v, o);
      chk("R6 random out", o, exp_out(is_bnd(c), n, v, bnd_capture));
      chk("R6 random drive", bnd_drive, exp_drive(is_bnd(c), n, v, bnd_capture, d_old));
      chk("R10 random extest", BL'(extest_on), BL'(c == 3'b000));
    end
    // R2: five highs from Shift-DR
    scan_ir(3'b000, cap);
    step(1, 0, 0, s); step(0, 0, 0, s); step(0, 0, 0, s);
    for (int k = 0; k < 5; k++) step(1, 0, (k == 0), s);
    step(0, 0, 0, s);
    chk("R2 from shift-dr", BL'(extest_on), '0);
    // R2: five highs from Pause-IR
    scan_ir(3'b010, cap);
    scan_ir(3'b000, cap);
    step(1, 0, 0, s); step(1, 0, 0, s); step(0, 0, 0, s); step(1, 0, 0, s); step(0, 0, 0, s);
    for (int k = 0; k < 5; k++) step(1, 0, 0, s);
    step(0, 0, 0, s);
    chk("R2 from pause-ir", BL'(extest_on), '0);
    v = rnd_vec(6); scan_dr(6, v, o);
    chk("R2 bypass restored", o, v >> 1);
    // R3: enable timing and falling-edge-only output
    chk("R3 enable pattern", BL'(oe_bad), '0);
    chk("R3 no rising-edge change", BL'(glitch), '0);
    // R1: reset mid-run
    scan_ir(3'b000, cap);
    @(negedge test_clk); #1; test_rst = 1'b1;
    repeat (2) @(posedge test_clk);
    @(negedge test_clk); #1; test_rst = 1'b0;
    chk("R1 reset drive", bnd_drive, '0);
    chk("R1 reset extest", BL'(extest_on), '0);
    finish_run();
  end
endmodule